// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of page table held in memory. A requester presents an address, a read/write flag and the current root table page. The walker then reads a first-level entry from the root table. If that entry is marked present, it reads a second-level entry from the table that the first entry names. It checks the access rights in the second-level entry and returns either a physical address or a fault.

The walker is a single sequential engine. It accepts one request at a time and has at most one memory read in flight. Its memory side is a plain read port: a one-cycle request pulse with an address, and a later one-cycle response pulse with the data. Each table is one 4 KB page of 1024 four-byte entries. The root page number is the only per-context state the requester has to supply.

Every entry uses the same layout. Bits [31:12] hold a page number: for a first-level entry, the page of the second-level table; for a second-level entry, the physical page. Bit 2 grants write, bit 1 grants read, and bit 0 marks the entry present. Bits [11:3] are ignored.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held, and in the first cycle after it, `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0.
- R2: The cycle after a request is accepted (`req_valid` and `req_ready` both high at a clock edge), the walker issues a read at byte address {root_base, vaddr[31:22], 2'b00}.
- R3: After a first-level entry with bit 0 set arrives, the next read goes to {entry[31:12], vaddr[21:12], 2'b00}.
- R4: If the first-level entry has bit 0 clear, no second read is made. The response then carries fault code 1 (not present) with level 0, whatever that entry's other bits hold.
- R5: If the second-level entry has bit 0 clear, the response carries fault code 1 with level 1, even when its permission bits are set.
- R6: A read request needs bit 1 of the second-level entry and a write request needs bit 2. A missing right gives fault code 2 (permission) with level 1. The permission bits of the first-level entry have no effect.
- R7: On success the fault code is 0, the level is 1, and `rsp_paddr` = {entry2[31:12], vaddr[11:0]}. On any fault `rsp_paddr` is 0.
- R8: `req_ready` is 0 from the cycle after acceptance until the response has been given. A request held during a walk is taken only after the response.
- R9: `rsp_valid` is a single-cycle pulse, given exactly once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| root_base | input | 20 | Page number of the first-level table |
| mem_req_valid | output | 1 | Table read request pulse |
| mem_req_addr | output | 32 | Byte address of the table entry to read |
| mem_rsp_valid | input | 1 | Read data pulse |
| mem_rsp_data | input | 32 | Table entry read from memory |
| rsp_valid | output | 1 | Translation result pulse |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 permission |
| rsp_level | output | 1 | Level of the result: 0 first, 1 second |
| rsp_paddr | output | 32 | Physical address, 0 on fault |

## Verification
A result and a new request can meet in the same cycle. In the response cycle a caller may already be holding the next request, but the walker must not take it until it is back in idle. The bench provokes this by issuing requests back to back, with `req_valid` held through each walk. A scoreboard then judges the stream: each accepted request must produce exactly one response and one set of table reads. A request taken early or twice would show up as an extra response, or as read addresses that do not match the expected walk. Memory latency is varied so that the overlap falls at different points in the walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W    = 32;
    localparam int L1_W    = 10;
    localparam int L2_W    = 10;
    localparam int OFF_W   = 12;
    localparam int PPN_W   = VA_W - OFF_W;
    localparam int PTE_W   = 32;
    localparam int ENT_LSB = $clog2(PTE_W / 8);
    localparam int RSV_W   = PTE_W - PPN_W - 3;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_ABSENT  = 2'd1,
        FLT_PERM    = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_CHECK,
        ST_RESP
    } walk_st_e;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic [RSV_W-1:0] rsvd;
        logic             wr_ok;
        logic             rd_ok;
        logic             present;
    } pte_t;

    typedef struct packed {
        logic [L1_W-1:0]  i1;
        logic [L2_W-1:0]  i2;
        logic [OFF_W-1:0] off;
    } vaddr_t;

    function automatic logic [VA_W-1:0] entry_addr(
        input logic [PPN_W-1:0] table_pg,
        input logic [L1_W-1:0]  idx
    );
        return {table_pg, idx, {ENT_LSB{1'b0}}};
    endfunction
endpackage

// File: rtl/ptw_addr_sel.sv
module ptw_addr_sel import ptw_pkg::*; (
    input  logic             sel_l2,
    input  logic [PPN_W-1:0] root_pg,
    input  logic [PPN_W-1:0] l2_pg,
    input  vaddr_t           va,
    output logic [VA_W-1:0]  addr
);
    always_comb begin
        if (sel_l2)
            addr = entry_addr(l2_pg, va.i2);
        else
            addr = entry_addr(root_pg, va.i1);
    end
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval import ptw_pkg::*; (
    input  pte_t              pte,
    input  logic              is_write,
    input  logic [OFF_W-1:0]  off,
    output fault_e            fault,
    output logic [VA_W-1:0]   paddr
);
    logic allowed;

    assign allowed = is_write ? pte.wr_ok : pte.rd_ok;

    always_comb begin
        fault = FLT_NONE;
        paddr = '0;
        if (!pte.present)
            fault = FLT_ABSENT;
        else if (!allowed)
            fault = FLT_PERM;
        else
            paddr = {pte.ppn, off};
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker import ptw_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic [PPN_W-1:0] root_base,
    output logic             mem_req_valid,
    output logic [VA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             rsp_valid,
    output logic [1:0]       rsp_fault,
    output logic             rsp_level,
    output logic [VA_W-1:0]  rsp_paddr
);
    walk_st_e         st;
    vaddr_t           va_q;
    logic             wr_q;
    logic [PPN_W-1:0] root_q;
    logic [PPN_W-1:0] l2pg_q;
    pte_t             pte2_q;
    fault_e           flt_q;
    logic             lvl_q;
    logic [VA_W-1:0]  pa_q;

    pte_t             rsp_pte;
    fault_e           ev_fault;
    logic [VA_W-1:0]  ev_paddr;

    assign rsp_pte = pte_t'(mem_rsp_data);

    ptw_addr_sel u_addr (
        .sel_l2  (st == ST_L2_REQ),
        .root_pg (root_q),
        .l2_pg   (l2pg_q),
        .va      (va_q),
        .addr    (mem_req_addr)
    );

    ptw_pte_eval u_eval (
        .pte      (pte2_q),
        .is_write (wr_q),
        .off      (va_q.off),
        .fault    (ev_fault),
        .paddr    (ev_paddr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            va_q   <= '0;
            wr_q   <= 1'b0;
            root_q <= '0;
            l2pg_q <= '0;
            pte2_q <= '0;
            flt_q  <= FLT_NONE;
            lvl_q  <= 1'b0;
            pa_q   <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= vaddr_t'(req_vaddr);
                        wr_q   <= req_write;
                        root_q <= root_base;
                        st     <= ST_L1_REQ;
                    end
                end
                ST_L1_REQ:  st <= ST_L1_WAIT;
                ST_L1_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!rsp_pte.present) begin
                            flt_q <= FLT_ABSENT;
                            lvl_q <= 1'b0;
                            pa_q  <= '0;
                            st    <= ST_RESP;
                        end else begin
                            l2pg_q <= rsp_pte.ppn;
                            st     <= ST_L2_REQ;
                        end
                    end
                end
                ST_L2_REQ:  st <= ST_L2_WAIT;
                ST_L2_WAIT: begin
                    if (mem_rsp_valid) begin
                        pte2_q <= rsp_pte;
                        st     <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    flt_q <= ev_fault;
                    lvl_q <= 1'b1;
                    pa_q  <= ev_paddr;
                    st    <= ST_RESP;
                end
                ST_RESP:  st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (st == ST_IDLE);
    assign mem_req_valid = (st == ST_L1_REQ) || (st == ST_L2_REQ);
    assign rsp_valid     = (st == ST_RESP);
    assign rsp_fault     = flt_q;
    assign rsp_level     = lvl_q;
    assign rsp_paddr     = pa_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk import ptw_pkg::*; (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_vaddr,
    input logic [PPN_W-1:0] root_base,
    input logic             mem_req_valid,
    input logic [VA_W-1:0]  mem_req_addr,
    input logic             mem_rsp_valid,
    input logic [PTE_W-1:0] mem_rsp_data,
    input logic             rsp_valid,
    input logic [1:0]       rsp_fault,
    input logic             rsp_level,
    input logic [VA_W-1:0]  rsp_paddr
);
    logic [VA_W-1:0] va_seen;

    always_ff @(posedge clk) begin
        if (rst)
            va_seen <= '0;
        else if (req_valid && req_ready)
            va_seen <= req_vaddr;
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !rsp_valid && !mem_req_valid));

    p_l1_addr_r2: assert property (@(posedge clk) disable iff (rst)
        $past(req_valid && req_ready) |->
            (mem_req_valid && mem_req_addr ==
             {$past(root_base), $past(req_vaddr[31:22]), 2'b00}));

    p_l2_addr_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(mem_rsp_valid) && mem_req_valid) |->
            (mem_req_addr == {$past(mem_rsp_data[31:12]), va_seen[21:12], 2'b00}));

    p_no_read_after_absent_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_rsp_valid && !mem_rsp_data[0]) |=> !mem_req_valid);

    p_level0_only_absent_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_level) |-> (rsp_fault == 2'd1));

    p_fault_zero_pa_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

    p_busy_no_ready_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid || rsp_valid) |-> !req_ready);

    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .root_base     (root_base),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_level     (rsp_level),
    .rsp_paddr     (rsp_paddr)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [19:0] root_base = '0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        req_ready, mem_req_valid, rsp_valid, rsp_level;
    logic [31:0] mem_req_addr, rsp_paddr;
    logic [1:0]  rsp_fault;

    always #4 clk = ~clk;

    ptw_walker u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .root_base(root_base),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_level(rsp_level),
        .rsp_paddr(rsp_paddr)
    );

    typedef struct {
        logic [1:0]  f;
        logic        lvl;
        logic [31:0] pa;
        int          n;
        logic [31:0] a1;
        logic [31:0] a2;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] got[$];
    logic [31:0] mem [logic [31:0]];
    int          mem_lat = 1;
    int          n_chk = 0;
    int          n_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_l1(input logic [19:0] root, input logic [9:0] i1, input logic [19:0] pg, input logic [2:0] bits);
        mem[{root, i1, 2'b00}] = {pg, 9'd0, bits};
    endtask

    task automatic put_l2(input logic [19:0] pg, input logic [9:0] i2, input logic [19:0] ppn, input logic [2:0] bits);
        mem[{pg, i2, 2'b00}] = {ppn, 9'd0, bits};
    endtask

    // memory model: one read at a time, response mem_lat negedges later
    initial begin
        @(negedge clk);
        forever begin
            if (mem_req_valid) begin
                logic [31:0] a;
                a = mem_req_addr;
                got.push_back(a);
                repeat (mem_lat) @(negedge clk);
                mem_rsp_data  = mem.exists(a) ? mem[a] : 32'd0;
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9 unexpected response", rsp_paddr, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(rsp_fault == e.f, {e.tag, " fault"}, {30'd0, rsp_fault}, {30'd0, e.f});
                chk(rsp_level == e.lvl, {e.tag, " level"}, {31'd0, rsp_level}, {31'd0, e.lvl});
                chk(rsp_paddr == e.pa, {e.tag, " paddr"}, rsp_paddr, e.pa);
                chk(got.size() == e.n, {e.tag, " read count"}, got.size(), e.n);
                if (got.size() >= 1)
                    chk(got[0] == e.a1, "R2 first read addr", got[0], e.a1);
                if (got.size() >= 2 && e.n >= 2)
                    chk(got[1] == e.a2, "R3 second read addr", got[1], e.a2);
            end
            got.delete();
        end
    end

    task automatic walk(input logic [19:0] root, input logic [9:0] i1, input logic [9:0] i2,
                        input logic [11:0] off, input bit wr, input logic [1:0] f, input bit lvl,
                        input logic [19:0] ppn, input int n, input logic [19:0] l2pg,
                        input bit hold, input string tag);
        exp_t e;
        e.f   = f;
        e.lvl = lvl;
        e.pa  = (f == 2'd0) ? {ppn, off} : 32'd0;
        e.n   = n;
        e.a1  = {root, i1, 2'b00};
        e.a2  = {l2pg, i2, 2'b00};
        e.tag = tag;
        sb.push_back(e);
        req_valid = 1'b1;
        req_vaddr = {i1, i2, off};
        req_write = wr;
        root_base = root;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        chk(!req_ready, "R8 ready low after accept", {31'd0, req_ready}, 32'd0);
        if (!hold) begin
            req_valid = 1'b0;
            while (sb.size() != 0) @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    localparam logic [19:0] RA = 20'h00010;
    localparam logic [19:0] RB = 20'h00020;
    localparam logic [19:0] T1 = 20'h00200;
    localparam logic [19:0] T2 = 20'h00300;

    initial begin
        put_l1(RA, 10'd3,   T1, 3'b001);
        put_l1(RA, 10'h101, T1, 3'b110);
        put_l1(RA, 10'h3FF, 20'hFFFFF, 3'b001);
        put_l1(RB, 10'd3,   T2, 3'b111);
        put_l2(T1, 10'd5, 20'h12345, 3'b011);
        put_l2(T1, 10'd6, 20'h0ABCD, 3'b111);
        put_l2(T1, 10'd7, 20'h55555, 3'b101);
        put_l2(T1, 10'd8, 20'h77777, 3'b110);
        put_l2(T2, 10'd5, 20'hFEDCB, 3'b011);
        put_l2(20'hFFFFF, 10'h3FF, 20'h00001, 3'b011);

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready in reset", {31'd0, req_ready}, 32'd1);
        chk(rsp_valid == 1'b0, "R1 no response in reset", {31'd0, rsp_valid}, 32'd0);
        chk(mem_req_valid == 1'b0, "R1 no read in reset", {31'd0, mem_req_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req_valid, "R1 idle after reset",
            {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'd4);

        walk(RA, 10'd3, 10'd5, 12'hABC, 0, 2'd0, 1, 20'h12345, 2, T1, 0, "R7 read ok");
        walk(RA, 10'd3, 10'd5, 12'hABC, 1, 2'd2, 1, 20'h0, 2, T1, 0, "R6 write to read-only");
        walk(RA, 10'd3, 10'd6, 12'h001, 1, 2'd0, 1, 20'h0ABCD, 2, T1, 0, "R6 write ok, l1 perms clear");
        walk(RA, 10'd3, 10'd7, 12'hFFF, 0, 2'd2, 1, 20'h0, 2, T1, 0, "R6 read of write-only");
        walk(RA, 10'd3, 10'd7, 12'h000, 1, 2'd0, 1, 20'h55555, 2, T1, 0, "R6 write to write-only");
        walk(RA, 10'd3, 10'd8, 12'h010, 0, 2'd1, 1, 20'h0, 2, T1, 0, "R5 absent second entry");
        walk(RA, 10'h100, 10'd5, 12'h0, 0, 2'd1, 0, 20'h0, 1, T1, 0, "R4 empty first entry");
        walk(RA, 10'h101, 10'd5, 12'h0, 1, 2'd1, 0, 20'h0, 1, T1, 0, "R4 absent first entry with bits");
        walk(RB, 10'd3, 10'd5, 12'h123, 0, 2'd0, 1, 20'hFEDCB, 2, T2, 0, "R2 other root");
        walk(RA, 10'h3FF, 10'h3FF, 12'hFFF, 0, 2'd0, 1, 20'h00001, 2, 20'hFFFFF, 0, "R3 top indices");

        mem_lat = 3;
        walk(RA, 10'd3, 10'd5, 12'h111, 0, 2'd0, 1, 20'h12345, 2, T1, 1, "R8 held a");
        walk(RA, 10'h100, 10'd0, 12'h0, 0, 2'd1, 0, 20'h0, 1, T1, 1, "R8 held b");
        walk(RA, 10'd3, 10'd5, 12'h222, 1, 2'd2, 1, 20'h0, 2, T1, 1, "R8 held c");
        walk(RB, 10'd3, 10'd5, 12'h333, 0, 2'd0, 1, 20'hFEDCB, 2, T2, 0, "R9 held d");

        mem_lat = 2;
        walk(RA, 10'd3, 10'd8, 12'h0, 1, 2'd1, 1, 20'h0, 2, T1, 1, "R5 held e");
        walk(RA, 10'h3FF, 10'h3FF, 12'h5A5, 0, 2'd0, 1, 20'h00001, 2, 20'hFFFFF, 0, "R7 held f");

        repeat (5) @(negedge clk);
        chk(sb.size() == 0, "R9 all responses seen", sb.size(), 32'd0);
        chk(!rsp_valid && req_ready, "R9 quiet at end", {30'd0, rsp_valid, req_ready}, 32'd1);
        finish_run();
    end
endmodule